// File: doc/BRIEF.md
# Sample Period Quantizer

This block turns a requested sample period, given in nanoseconds, into a period that a converter clock tree can actually produce. The tree selects one of a few fixed master clock periods and stretches it by a power-of-two factor of 1, 2, 4 or 8. Two board variants exist. One has four master clocks. The other has three.

A request is accepted on a one-cycle `start` strobe. The block first clamps the request to the range the variant can produce. It then walks the candidate grid one entry per clock cycle. During the walk it tracks the tightest achievable period below the clamped request and the tightest achievable period above it. When the walk ends, the rounding mode picks one of the two bounds.

The result appears as three values: the achieved period, the chosen clock index and the chosen divisor shift. The index and shift are also packed into a configuration word at the bit positions a clock-control register decodes. A one-cycle `done` pulse marks that the result is fresh.

Top module: `sample_period_quantizer`

## Requirements
- R1: `board_sel` = 0 selects master clocks 31250, 22676, 20833 and 19531 ns at indices 0 to 3. `board_sel` = 1 selects 62500, 50000 and 41667 ns at indices 0 to 2, and index 3 is never reported for that variant.
- R2: Every achieved period equals the master clock at `clk_index` multiplied by 2 to the power `div_shift`, where `div_shift` ranges over 0 to 3.
- R3: The request is clamped from below to the fastest clock at factor 1, and from above to the index-0 clock at factor 8.
- R4: With `round_mode` = 2'b01 (up), the result is the smallest achievable period at or above the clamped request.
- R5: With `round_mode` = 2'b10 (down), the result is the largest achievable period at or below the clamped request.
- R6: With `round_mode` = 2'b00 or 2'b11 (nearest), the upper bound is returned only when it is strictly closer to the clamped request. Otherwise, including on a tie, the lower bound is returned.
- R7: An exactly achievable request returns itself. The reported fields are those of the first matching candidate in the search order, which runs shifts 0 to 3 in the outer loop and indices in the inner loop.
- R8: `cfg_word[4:3]` carries the clock index, `cfg_word[6:5]` carries the divisor shift, and `cfg_word[2:0]` is zero.
- R9: `done` is high for exactly one cycle per accepted request. Outputs hold their values until the next `done`.
- R10: A `start` that arrives while a search is in progress is ignored and does not change the pending result.
- R11: After reset, all outputs are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| req_period | input | 32 | Requested period in ns, unsigned |
| round_mode | input | 2 | 00/11 nearest, 01 up, 10 down |
| board_sel | input | 1 | Board variant: 0 four clocks, 1 three clocks |
| achieved_period | output | 32 | Producible period in ns |
| clk_index | output | 2 | Selected master clock |
| div_shift | output | 2 | Selected power-of-two multiplier exponent |
| cfg_word | output | 7 | Configuration word with index at 4:3 and shift at 6:5 |
| done | output | 1 | Result valid pulse |

## Verification
The assertions assume that `round_mode` and `board_sel` are meaningful only when captured with an accepted `start`. They also assume that the request may be any 32-bit value, including zero and all ones, because the clamp must absorb it. The stimulus drives inputs only on falling edges, holds `start` for a single cycle, and waits for `done` before issuing the next request. The one exception is a deliberate second strobe in the middle of a search, which tests that such a strobe is ignored. Requests are chosen on both clamp edges, at exact grid points, at exact midpoints, and one nanosecond past a midpoint, so that every rounding path is taken.

// File: rtl/sample_period_quantizer.sv
module sample_period_quantizer #(
  parameter int W      = 32,
  parameter int A_CLK0 = 31250,
  parameter int A_CLK1 = 22676,
  parameter int A_CLK2 = 20833,
  parameter int A_CLK3 = 19531,
  parameter int B_CLK0 = 62500,
  parameter int B_CLK1 = 50000,
  parameter int B_CLK2 = 41667
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] req_period,
  input  logic [1:0]   round_mode,
  input  logic         board_sel,
  output logic [W-1:0] achieved_period,
  output logic [1:0]   clk_index,
  output logic [1:0]   div_shift,
  output logic [6:0]   cfg_word,
  output logic         done
);

  localparam logic [1:0] MODE_UP   = 2'b01;
  localparam logic [1:0] MODE_DOWN = 2'b10;
  localparam logic [1:0] MAX_SHIFT = 2'd3;

  function automatic logic [W-1:0] master(input logic sel, input logic [1:0] i);
    logic [W-1:0] v;
    if (!sel)
      case (i)
        2'd0: v = W'(A_CLK0);
        2'd1: v = W'(A_CLK1);
        2'd2: v = W'(A_CLK2);
        default: v = W'(A_CLK3);
      endcase
    else
      case (i)
        2'd0: v = W'(B_CLK0);
        2'd1: v = W'(B_CLK1);
        default: v = W'(B_CLK2);
      endcase
    return v;
  endfunction

  function automatic logic [1:0] last_of(input logic sel);
    return sel ? 2'd2 : 2'd3;
  endfunction

  logic         busy, fin;
  logic         sel_q;
  logic [1:0]   mode_q;
  logic [W-1:0] req_q;
  logic [W-1:0] lub_q, glb_q;
  logic [1:0]   lub_i, lub_s, glb_i, glb_s;
  logic [1:0]   idx, sh;

  logic [W-1:0] in_lo, in_hi, in_clamped;
  assign in_lo      = master(board_sel, last_of(board_sel));
  assign in_hi      = master(board_sel, 2'd0) << MAX_SHIFT;
  assign in_clamped = (req_period < in_lo) ? in_lo :
                      (req_period > in_hi) ? in_hi : req_period;

  logic [W-1:0] cand;
  logic         take_lub, take_glb, last_cand;
  assign cand      = master(sel_q, idx) << sh;
  assign take_lub  = (cand < lub_q) && (cand >= req_q);
  assign take_glb  = (cand > glb_q) && (cand <= req_q);
  assign last_cand = (sh == MAX_SHIFT) && (idx == last_of(sel_q));

  logic         pick_up;
  logic [W-1:0] pick_val;
  logic         use_lub;
  assign pick_up  = (mode_q == MODE_UP)   ? 1'b1 :
                    (mode_q == MODE_DOWN) ? 1'b0 :
                    ((lub_q - req_q) < (req_q - glb_q));
  assign pick_val = pick_up ? lub_q : glb_q;
  assign use_lub  = (pick_val == lub_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      sel_q  <= 1'b0;
      mode_q <= 2'b00;
      req_q  <= '0;
      lub_q  <= '0;
      glb_q  <= '0;
      lub_i  <= 2'd0;
      lub_s  <= 2'd0;
      glb_i  <= 2'd0;
      glb_s  <= 2'd0;
      idx    <= 2'd0;
      sh     <= 2'd0;
    end else if (start && !busy && !fin) begin
      busy   <= 1'b1;
      sel_q  <= board_sel;
      mode_q <= round_mode;
      req_q  <= in_clamped;
      lub_q  <= in_hi;
      lub_i  <= 2'd0;
      lub_s  <= MAX_SHIFT;
      glb_q  <= in_lo;
      glb_i  <= last_of(board_sel);
      glb_s  <= 2'd0;
      idx    <= 2'd0;
      sh     <= 2'd0;
    end else if (busy) begin
      if (take_lub) begin
        lub_q <= cand;
        lub_i <= idx;
        lub_s <= sh;
      end
      if (take_glb) begin
        glb_q <= cand;
        glb_i <= idx;
        glb_s <= sh;
      end
      if (last_cand) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end else if (idx == last_of(sel_q)) begin
        idx <= 2'd0;
        sh  <= sh + 2'd1;
      end else begin
        idx <= idx + 2'd1;
      end
    end else if (fin) begin
      fin <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      achieved_period <= '0;
      clk_index       <= 2'd0;
      div_shift       <= 2'd0;
      done            <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        achieved_period <= pick_val;
        clk_index       <= use_lub ? lub_i : glb_i;
        div_shift       <= use_lub ? lub_s : glb_s;
      end
    end
  end

  assign cfg_word = {div_shift, clk_index, 3'b000};

endmodule

module sample_period_quantizer_chk #(
  parameter int W      = 32,
  parameter int A_CLK0 = 31250,
  parameter int A_CLK1 = 22676,
  parameter int A_CLK2 = 20833,
  parameter int A_CLK3 = 19531,
  parameter int B_CLK0 = 62500,
  parameter int B_CLK1 = 50000,
  parameter int B_CLK2 = 41667
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         busy,
  input logic         sel_q,
  input logic [1:0]   mode_q,
  input logic [W-1:0] req_q,
  input logic [W-1:0] achieved_period,
  input logic [1:0]   clk_index,
  input logic [1:0]   div_shift
);

  function automatic logic [W-1:0] ref_clk(input logic sel, input logic [1:0] i);
    logic [W-1:0] v;
    if (!sel)
      case (i)
        2'd0: v = W'(A_CLK0);
        2'd1: v = W'(A_CLK1);
        2'd2: v = W'(A_CLK2);
        default: v = W'(A_CLK3);
      endcase
    else
      case (i)
        2'd0: v = W'(B_CLK0);
        2'd1: v = W'(B_CLK1);
        2'd2: v = W'(B_CLK2);
        default: v = '0;
      endcase
    return v;
  endfunction

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(achieved_period) && $stable(clk_index) && $stable(div_shift));

  // R2
  grid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> achieved_period == (ref_clk(sel_q, clk_index) << div_shift));

  // R4
  round_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 2'b01 |-> achieved_period >= req_q);

  // R5
  round_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 2'b10 |-> achieved_period <= req_q);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(req_q));

  // R1
  variant_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && sel_q |-> clk_index != 2'd3);

endmodule

bind sample_period_quantizer sample_period_quantizer_chk #(
  .W(W), .A_CLK0(A_CLK0), .A_CLK1(A_CLK1), .A_CLK2(A_CLK2), .A_CLK3(A_CLK3),
  .B_CLK0(B_CLK0), .B_CLK1(B_CLK1), .B_CLK2(B_CLK2)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
  .sel_q(sel_q), .mode_q(mode_q), .req_q(req_q),
  .achieved_period(achieved_period), .clk_index(clk_index), .div_shift(div_shift)
);

// File: tb/test_sample_period_quantizer.sv
module test_sample_period_quantizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_period = '0;
  logic [1:0]  round_mode = 2'b00;
  logic        board_sel = 1'b0;
  logic [31:0] achieved_period;
  logic [1:0]  clk_index, div_shift;
  logic [6:0]  cfg_word;
  logic        done;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sample_period_quantizer i_sample_period_quantizer (
    .clk(clk), .rst_n(rst_n), .start(start), .req_period(req_period),
    .round_mode(round_mode), .board_sel(board_sel),
    .achieved_period(achieved_period), .clk_index(clk_index),
    .div_shift(div_shift), .cfg_word(cfg_word), .done(done)
  );

  // {board_sel, round_mode, request, expected period, expected index, expected shift}
  localparam int NV = 17;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 2'b00, 32'd21000,      32'd20833,  2'd2, 2'd0},
    {1'b0, 2'b01, 32'd21000,      32'd22676,  2'd1, 2'd0},
    {1'b0, 2'b10, 32'd21000,      32'd20833,  2'd2, 2'd0},
    {1'b0, 2'b00, 32'd100,        32'd19531,  2'd3, 2'd0},
    {1'b0, 2'b01, 32'd1000000,    32'd250000, 2'd0, 2'd3},
    {1'b0, 2'b00, 32'd45352,      32'd45352,  2'd1, 2'd1},
    {1'b0, 2'b00, 32'd40364,      32'd39062,  2'd3, 2'd1},
    {1'b0, 2'b00, 32'd40365,      32'd41666,  2'd2, 2'd1},
    {1'b0, 2'b11, 32'd100000,     32'd90704,  2'd1, 2'd2},
    {1'b0, 2'b10, 32'hFFFF_FFFF,  32'd250000, 2'd0, 2'd3},
    {1'b1, 2'b00, 32'd0,          32'd41667,  2'd2, 2'd0},
    {1'b1, 2'b10, 32'd600000,     32'd500000, 2'd0, 2'd3},
    {1'b1, 2'b00, 32'd90000,      32'd83334,  2'd2, 2'd1},
    {1'b1, 2'b01, 32'd90000,      32'd100000, 2'd1, 2'd1},
    {1'b1, 2'b00, 32'd19531,      32'd41667,  2'd2, 2'd0},
    {1'b1, 2'b01, 32'd70000,      32'd83334,  2'd2, 2'd1},
    {1'b1, 2'b10, 32'd70000,      32'd62500,  2'd0, 2'd0}
  };

  function automatic string tag_of(input int i);
    case (i)
      3, 4, 9, 11: return "R3";
      5:           return "R7";
      10, 14:      return "R1";
      1, 13, 15:   return "R4";
      2, 16:       return "R5";
      default:     return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        break;
      end
    end
  endtask

  task automatic issue(input logic sel, input logic [1:0] mode, input logic [31:0] req);
    @(negedge clk);
    board_sel  = sel;
    round_mode = mode;
    req_period = req;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    bit seen;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(achieved_period == 0, "R11", achieved_period, 0);
    chk(cfg_word == 0, "R11", 32'(cfg_word), 0);
    chk(done == 1'b0, "R11", 32'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R11", 32'(done), 0);

    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VEC[i];
      issue(v[70], v[69:68], v[67:36]);
      wait_done(seen);
      chk(seen, "R9", 32'(seen), 1);
      chk(achieved_period == v[35:4], tag_of(i), achieved_period, v[35:4]);
      chk(clk_index == v[3:2], tag_of(i), 32'(clk_index), 32'(v[3:2]));
      chk(div_shift == v[1:0], "R2", 32'(div_shift), 32'(v[1:0]));
      // R8: configuration word field positions
      chk(cfg_word == {v[1:0], v[3:2], 3'b000}, "R8", 32'(cfg_word), 32'({v[1:0], v[3:2], 3'b000}));
      @(negedge clk);
      chk(done == 1'b0, "R9", 32'(done), 0);
    end

    // R9: outputs hold after the pulse while inputs change
    held = achieved_period;
    req_period = 32'd12345;
    round_mode = 2'b01;
    repeat (6) @(negedge clk);
    chk(achieved_period == held, "R9", achieved_period, held);
    chk(done == 1'b0, "R9", 32'(done), 0);

    // R10: second strobe during search is ignored
    issue(1'b0, 2'b01, 32'd21000);
    @(negedge clk);
    board_sel  = 1'b1;
    round_mode = 2'b10;
    req_period = 32'd100000;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
    wait_done(seen);
    chk(seen, "R10", 32'(seen), 1);
    chk(achieved_period == 32'd22676, "R10", achieved_period, 32'd22676);
    chk(clk_index == 2'd1, "R10", 32'(clk_index), 1);
    repeat (25) @(negedge clk);
    chk(done == 1'b0, "R10", 32'(done), 0);
    chk(achieved_period == 32'd22676, "R10", achieved_period, 32'd22676);

    // R11: asynchronous reset clears a result
    rst_n = 1'b0;
    @(negedge clk);
    chk(achieved_period == 0 && cfg_word == 0, "R11", achieved_period, 0);
    finish_run();
  end

endmodule